// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller

The controller connects a simple host request port to asynchronous SRAM- or NOR-style devices on four active-low chip selects. The two top host address bits select one of four 64 MB windows, which gives 256 MB in total. Each window has its own 32-bit configuration word. The word sets, in clock cycles, the setup, strobe and hold lengths for reads and for writes. It also sets a turnaround gap, the external bus width (8 or 16 bits), a mode in which the chip select is asserted only during the strobe, and a mode in which the device can stretch the strobe through a wait input.

Every access runs through three phases: setup, strobe and hold. Output enable (reads) or write enable (writes) is active only during the strobe. The address is captured when the access starts and does not change until the next access. The host holds its request until `reqReady` pulses on the final hold cycle, and read data is valid on `rdData` in that cycle. The configuration words sit in a small register bank at byte offsets 0x10, 0x14, 0x18 and 0x1C.

Top module: `asyncBusCtrl`

## Requirements
- R1: After reset all chip selects, `emOeN` and `emWeN` are high, `emDataOe` and `reqReady` are low, and every configuration word reads as zero.
- R2: The configuration word for chip select n is written and read at byte offset 0x10+4n. Field layout: [1:0] bus size, [3:2] turnaround, [6:4] read hold, [12:7] read strobe, [16:13] read setup, [19:17] write hold, [25:20] write strobe, [29:26] write setup, bit 30 extended wait, bit 31 select strobe. A write to any other offset, including a misaligned one, changes no word.
- R3: Host address bits [27:26] pick the chip select, and at most one chip select is low at any time.
- R4: A read gives read setup+1 cycles with the chip select low and `emOeN` high, then read strobe+1 cycles with `emOeN` low, then read hold+1 cycles. `reqReady` is high for exactly the final hold cycle.
- R5: A write uses the write setup, strobe and hold fields in the same way. `emWeN` is low only during the strobe, and `emOeN` never goes low during a write.
- R6: `emDataOe` is high during every cycle of a write access, from setup through hold, and never during a read.
- R7: Read data is the value on `emDataIn` in the last strobe cycle. Later changes on `emDataIn` do not affect it.
- R8: Bus size 0 selects an 8-bit bus: `emAddr` equals host address bits [25:0], `emDataOut[15:8]` is zero and `rdData[15:8]` is zero. Bus size 1 selects a 16-bit bus: `emAddr` equals host address bits [25:1], and all 16 data bits pass through.
- R9: With select strobe set, the chip select is low only during the strobe cycles.
- R10: With extended wait set, a high `emWait` in the last strobe cycle extends the strobe until `emWait` is low. With extended wait clear, `emWait` is ignored.
- R11: An access that targets a different chip select, or reverses direction, starts only after the previous access's turnaround+1 idle cycles. Otherwise one idle cycle separates back-to-back accesses.
- R12: `emAddr` stays constant from the start of an access until its end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWdata | input | 32 | Configuration write data |
| cfgRdata | output | 32 | Configuration word at `cfgAddr`, zero if none |
| reqValid | input | 1 | Host access request, held until ready |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 28 | Host byte address |
| reqWdata | input | 16 | Host write data |
| reqReady | output | 1 | Access complete (final hold cycle) |
| rdData | output | 16 | Captured read data |
| emAddr | output | 26 | External address |
| emDataIn | input | 16 | External data from device |
| emDataOut | output | 16 | External data to device |
| emDataOe | output | 1 | External data output enable |
| emCsN | output | 4 | Active-low chip selects |
| emOeN | output | 1 | Active-low output enable |
| emWeN | output | 1 | Active-low write enable |
| emWait | input | 1 | Device wait request |

## Verification
The bench builds the block with its default parameters: four chip selects, a 28-bit host address and a 16-bit data path. These defaults make every chip-select window reachable, and with it the turnaround rule across windows and directions. Because each window is programmed separately, the bench can put 8-bit and 16-bit buses, select-strobe and extended-wait modes side by side and switch between them from one access to the next. The bench changes the external data on every strobe cycle, so a read shows exactly which cycle was captured.

// File: rtl/asyncBusPkg.sv
package asyncBusPkg;
  localparam int SIZE_W  = 2;
  localparam int TURN_W  = 2;
  localparam int HOLD_W  = 3;
  localparam int STRB_W  = 6;
  localparam int SETUP_W = 4;

  // Field order is software-visible; MSB first.
  typedef struct packed {
    logic               ssEn;
    logic               ewEn;
    logic [SETUP_W-1:0] wSetup;
    logic [STRB_W-1:0]  wStrobe;
    logic [HOLD_W-1:0]  wHold;
    logic [SETUP_W-1:0] rSetup;
    logic [STRB_W-1:0]  rStrobe;
    logic [HOLD_W-1:0]  rHold;
    logic [TURN_W-1:0]  turn;
    logic [SIZE_W-1:0]  busSize;
  } csCfgT;

  typedef struct packed {
    logic load;
    logic capture;
    logic csOn;
    logic oeOn;
    logic weOn;
    logic dataOe;
    logic wide;
  } dpCtlT;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phaseT;
endpackage

// File: rtl/asyncBusRegs.sv
module asyncBusRegs #(
  parameter int NUM_CS = 4,
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] CFG_BASE = 8'h10
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cfgWe,
  input  logic [REG_AW-1:0]      cfgAddr,
  input  logic [31:0]            cfgWdata,
  output logic [31:0]            cfgRdata,
  output logic [NUM_CS-1:0][31:0] cfgBank
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic [REG_AW-1:0] offset;
  logic              hit;
  logic [IDX_W-1:0]  idx;

  assign offset = cfgAddr - CFG_BASE;
  assign hit    = (cfgAddr >= CFG_BASE) && (offset < REG_AW'(NUM_CS * 4)) && (offset[1:0] == 2'b00);
  assign idx    = offset[IDX_W+1:2];

  for (genvar g = 0; g < NUM_CS; g++) begin : gWord
    always_ff @(posedge clk) begin
      if (!rstN)                                  cfgBank[g] <= '0;
      else if (cfgWe && hit && idx == IDX_W'(g))  cfgBank[g] <= cfgWdata;
    end
  end

  assign cfgRdata = hit ? cfgBank[idx] : '0;
endmodule

// File: rtl/asyncBusSeq.sv
module asyncBusSeq
  import asyncBusPkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       reqValid,
  input  logic                       reqWrite,
  input  logic [$clog2(NUM_CS)-1:0]  reqCs,
  input  csCfgT                      cfgIn,
  input  logic                       emWait,
  output logic                       reqReady,
  output dpCtlT                      ctl
);
  localparam int IDX_W = $clog2(NUM_CS);

  phaseT             ph;
  logic [STRB_W-1:0] cnt;
  csCfgT             cur;
  logic              curWr, lastVal, lastWr;
  logic [IDX_W-1:0]  curCs, lastCs;
  logic [TURN_W-1:0] lastTurn, idleCnt;
  logic              needTurn, canStart, lastCnt, stretch;

  assign needTurn = lastVal && ((reqCs != lastCs) || (reqWrite != lastWr));
  assign canStart = (ph == PH_IDLE) && reqValid && (!needTurn || idleCnt >= lastTurn);
  assign lastCnt  = (cnt == '0);
  assign stretch  = cur.ewEn && emWait;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ph <= PH_IDLE; cnt <= '0; cur <= '0; curWr <= 1'b0; curCs <= '0;
      lastVal <= 1'b0; lastWr <= 1'b0; lastCs <= '0; lastTurn <= '0; idleCnt <= '0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (canStart) begin
            ph    <= PH_SETUP;
            cnt   <= reqWrite ? STRB_W'(cfgIn.wSetup) : STRB_W'(cfgIn.rSetup);
            cur   <= cfgIn;
            curWr <= reqWrite;
            curCs <= reqCs;
          end else if (idleCnt != '1) begin
            idleCnt <= idleCnt + 1'b1;
          end
        end
        PH_SETUP: begin
          if (lastCnt) begin
            ph  <= PH_STROBE;
            cnt <= curWr ? cur.wStrobe : cur.rStrobe;
          end else cnt <= cnt - 1'b1;
        end
        PH_STROBE: begin
          if (lastCnt) begin
            if (!stretch) begin
              ph  <= PH_HOLD;
              cnt <= curWr ? STRB_W'(cur.wHold) : STRB_W'(cur.rHold);
            end
          end else cnt <= cnt - 1'b1;
        end
        PH_HOLD: begin
          if (lastCnt) begin
            ph       <= PH_IDLE;
            idleCnt  <= '0;
            lastVal  <= 1'b1;
            lastCs   <= curCs;
            lastWr   <= curWr;
            lastTurn <= cur.turn;
          end else cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.load    = canStart;
    ctl.capture = (ph == PH_STROBE) && lastCnt && !curWr && !stretch;
    ctl.csOn    = (ph == PH_STROBE) || (((ph == PH_SETUP) || (ph == PH_HOLD)) && !cur.ssEn);
    ctl.oeOn    = (ph == PH_STROBE) && !curWr;
    ctl.weOn    = (ph == PH_STROBE) && curWr;
    ctl.dataOe  = (ph != PH_IDLE) && curWr;
    ctl.wide    = (ph == PH_IDLE) ? (cfgIn.busSize == SIZE_W'(1)) : (cur.busSize == SIZE_W'(1));
  end

  assign reqReady = (ph == PH_HOLD) && lastCnt;
endmodule

// File: rtl/asyncBusDp.sv
module asyncBusDp
  import asyncBusPkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  dpCtlT                                  ctl,
  input  logic [ADDR_W-1:0]                      reqAddr,
  input  logic [DATA_W-1:0]                      reqWdata,
  input  logic [DATA_W-1:0]                      emDataIn,
  output logic [ADDR_W-$clog2(NUM_CS)-1:0]       emAddr,
  output logic [DATA_W-1:0]                      emDataOut,
  output logic                                   emDataOe,
  output logic [NUM_CS-1:0]                      emCsN,
  output logic                                   emOeN,
  output logic                                   emWeN,
  output logic [DATA_W-1:0]                      rdData
);
  localparam int IDX_W  = $clog2(NUM_CS);
  localparam int WIN_W  = ADDR_W - IDX_W;
  localparam int BYTE_W = DATA_W / 2;

  logic [WIN_W-1:0]  addrQ;
  logic [DATA_W-1:0] wdQ, rdQ;
  logic [IDX_W-1:0]  csQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0; wdQ <= '0; rdQ <= '0; csQ <= '0;
    end else begin
      if (ctl.load) begin
        csQ   <= reqAddr[ADDR_W-1:WIN_W];
        addrQ <= ctl.wide ? {1'b0, reqAddr[WIN_W-1:1]} : reqAddr[WIN_W-1:0];
        wdQ   <= reqWdata;
      end
      if (ctl.capture)
        rdQ <= ctl.wide ? emDataIn : DATA_W'(emDataIn[BYTE_W-1:0]);
    end
  end

  for (genvar g = 0; g < NUM_CS; g++) begin : gCs
    assign emCsN[g] = !(ctl.csOn && (csQ == IDX_W'(g)));
  end

  assign emAddr    = addrQ;
  assign emDataOut = ctl.wide ? wdQ : DATA_W'(wdQ[BYTE_W-1:0]);
  assign emDataOe  = ctl.dataOe;
  assign emOeN     = !ctl.oeOn;
  assign emWeN     = !ctl.weOn;
  assign rdData    = rdQ;
endmodule

// File: rtl/asyncBusCtrl.sv
module asyncBusCtrl
  import asyncBusPkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 28,
  parameter int DATA_W = 16,
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] CFG_BASE = 8'h10
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgWe,
  input  logic [REG_AW-1:0]                 cfgAddr,
  input  logic [31:0]                       cfgWdata,
  output logic [31:0]                       cfgRdata,
  input  logic                              reqValid,
  input  logic                              reqWrite,
  input  logic [ADDR_W-1:0]                 reqAddr,
  input  logic [DATA_W-1:0]                 reqWdata,
  output logic                              reqReady,
  output logic [DATA_W-1:0]                 rdData,
  output logic [ADDR_W-$clog2(NUM_CS)-1:0]  emAddr,
  input  logic [DATA_W-1:0]                 emDataIn,
  output logic [DATA_W-1:0]                 emDataOut,
  output logic                              emDataOe,
  output logic [NUM_CS-1:0]                 emCsN,
  output logic                              emOeN,
  output logic                              emWeN,
  input  logic                              emWait
);
  localparam int IDX_W = $clog2(NUM_CS);

  logic [NUM_CS-1:0][31:0] cfgBank;
  logic [IDX_W-1:0]        reqCs;
  csCfgT                   cfgSel;
  dpCtlT                   ctl;

  assign reqCs  = reqAddr[ADDR_W-1 -: IDX_W];
  assign cfgSel = csCfgT'(cfgBank[reqCs]);

  asyncBusRegs #(.NUM_CS(NUM_CS), .REG_AW(REG_AW), .CFG_BASE(CFG_BASE)) regs_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .cfgBank(cfgBank));

  asyncBusSeq #(.NUM_CS(NUM_CS)) seq_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqCs(reqCs),
    .cfgIn(cfgSel), .emWait(emWait), .reqReady(reqReady), .ctl(ctl));

  asyncBusDp #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .emDataIn(emDataIn), .emAddr(emAddr), .emDataOut(emDataOut), .emDataOe(emDataOe),
    .emCsN(emCsN), .emOeN(emOeN), .emWeN(emWeN), .rdData(rdData));
endmodule

// File: rtl/asyncBusCtrl_chk.sv
module asyncBusCtrl_chk #(
  parameter int NUM_CS = 4,
  parameter int AW     = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic [AW-1:0]     emAddr,
  input logic              emDataOe,
  input logic [NUM_CS-1:0] emCsN,
  input logic              emOeN,
  input logic              emWeN
);
  a_r3_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~emCsN));

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!emOeN && !emWeN));

  a_r6_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    emDataOe |-> emOeN);

  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  a_r4_ready_strobe_off: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (emOeN && emWeN));

  a_r12_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    ((!emOeN || !emWeN) && $past(!emOeN || !emWeN)) |-> $stable(emAddr));
endmodule

bind asyncBusCtrl asyncBusCtrl_chk #(.NUM_CS(NUM_CS), .AW(ADDR_W - $clog2(NUM_CS))) chk_i (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .emAddr(emAddr), .emDataOe(emDataOe),
  .emCsN(emCsN), .emOeN(emOeN), .emWeN(emWeN));

// File: tb/asyncBusCtrl_tb_top.sv
module asyncBusCtrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [27:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady;
  logic [15:0] rdData;
  logic [25:0] emAddr;
  logic [15:0] emDataIn = '0;
  logic [15:0] emDataOut;
  logic        emDataOe;
  logic [3:0]  emCsN;
  logic        emOeN, emWeN;
  logic        emWait = 1'b0;

  int checks = 0, failures = 0, cyc = 0;

  // per-access observations
  int gWait, gPre, gStrobe, gPost, gCsLow, gDoe;
  logic [15:0] gRd, gDout;
  logic [25:0] gAddr;
  logic [3:0]  gCsPat;
  bit gOeBad, gAddrMoved;

  always #5 clk = ~clk;

  asyncBusCtrl dut_i (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      failures++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 50000)", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCfg(input bit ss, input bit ew, input int ws, input int wst,
                                        input int wh, input int rs, input int rst, input int rh,
                                        input int ta, input int sz);
    return {ss, ew, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst), 3'(rh), 2'(ta), 2'(sz)};
  endfunction

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic cfgRead(input logic [7:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  // Called right after a negedge; returns at the negedge where ready was seen.
  task automatic runAccess(input bit wr, input logic [27:0] a, input logic [15:0] wd,
                           input int waitLen, input logic [15:0] dinBase);
    bit seenStrobe = 0, started = 0, done = 0;
    logic [25:0] firstAddr = '0;
    gWait = 0; gPre = 0; gStrobe = 0; gPost = 0; gCsLow = 0; gDoe = 0;
    gOeBad = 0; gAddrMoved = 0; gCsPat = 4'hF; gRd = '0; gDout = '0; gAddr = '0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd;
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk);
      if (!emOeN || !emWeN) begin
        gStrobe++;
        seenStrobe = 1;
        emWait   = (gStrobe <= waitLen);
        emDataIn = dinBase + 16'(gStrobe);
        gAddr = emAddr; gDout = emDataOut;
        if (wr ? !emOeN : !emWeN) gOeBad = 1;
      end else begin
        emWait = 1'b0;
        if (seenStrobe) begin gPost++; emDataIn = 16'hDEAD; end
        else if (emCsN != 4'hF || emDataOe) gPre++;
        else gWait++;
      end
      if (emCsN != 4'hF || emDataOe || !emOeN || !emWeN) begin
        if (!started) begin started = 1; firstAddr = emAddr; end
        else if (emAddr != firstAddr) gAddrMoved = 1;
      end
      if (emCsN != 4'hF) begin gCsLow++; gCsPat = emCsN; end
      if (emDataOe) gDoe++;
      if (!wr && emDataOe) gOeBad = 1;
      if (reqReady) begin gRd = rdData; reqValid = 1'b0; done = 1; end
    end
    if (!done) check(0, "access never completed", 0, 1);
  endtask

  task automatic testReset();
    logic [31:0] d;
    check(emCsN == 4'hF, "R1 chip selects idle", emCsN, 4'hF);
    check(emOeN && emWeN, "R1 strobes idle", {emOeN, emWeN}, 2'b11);
    check(!emDataOe && !reqReady, "R1 drive/ready idle", {emDataOe, reqReady}, 0);
    cfgRead(8'h1C, d);
    check(d == 0, "R1 config word reset", d, 0);
  endtask

  task automatic testRegs();
    logic [31:0] d;
    for (int n = 0; n < 4; n++) cfgWrite(8'(8'h10 + 4 * n), 32'hA5000000 | n);
    cfgWrite(8'h20, 32'h11111111);
    cfgWrite(8'h0C, 32'h22222222);
    cfgWrite(8'h11, 32'h33333333);
    for (int n = 0; n < 4; n++) begin
      cfgRead(8'(8'h10 + 4 * n), d);
      check(d == (32'hA5000000 | n), "R2 word readback / stray writes ignored", d, 32'hA5000000 | n);
    end
    cfgRead(8'h20, d);
    check(d == 0, "R2 unmapped offset reads zero", d, 0);
  endtask

  task automatic testRead16();
    // cs1: 16-bit, ta=2, rs=2 rst=3 rh=1; writes ws=1 wst=2 wh=0
    cfgWrite(8'h14, mkCfg(0, 0, 1, 2, 0, 2, 3, 1, 2, 1));
    runAccess(0, 28'h4ABCDE6, 16'h0, 0, 16'h1200);
    check(gWait == 0, "R11 first access no gap", gWait, 0);
    check(gPre == 3, "R4 read setup cycles", gPre, 3);
    check(gStrobe == 4, "R4 read strobe cycles", gStrobe, 4);
    check(gPost == 2, "R4 read hold cycles", gPost, 2);
    check(gCsPat == 4'b1101 && gCsLow == 9, "R3 cs1 decoded", {gCsPat, 8'(gCsLow)}, {4'b1101, 8'd9});
    check(gRd == 16'h1204, "R7 capture at last strobe", gRd, 16'h1204);
    check(gAddr == 26'h055E6F3, "R8 16-bit address", gAddr, 26'h055E6F3);
    check(!gOeBad && gDoe == 0, "R6 no drive on read", gDoe, 0);
    check(!gAddrMoved, "R12 address stable", gAddrMoved, 0);
  endtask

  task automatic testWriteTurn();
    runAccess(1, 28'h4000100, 16'hBEEF, 0, 16'h0);
    check(gWait == 3, "R11 direction reversal waits ta+1", gWait, 3);
    check(gPre == 2 && gStrobe == 3 && gPost == 1, "R5 write phase lengths",
          {8'(gPre), 8'(gStrobe), 8'(gPost)}, {8'd2, 8'd3, 8'd1});
    check(gDoe == 6, "R6 drive spans whole write", gDoe, 6);
    check(!gOeBad, "R5 no output enable on write", gOeBad, 0);
    check(gDout == 16'hBEEF, "R8 16-bit write data", gDout, 16'hBEEF);
    runAccess(1, 28'h4000102, 16'h1234, 0, 16'h0);
    check(gWait == 1, "R11 same cs same direction one idle", gWait, 1);
  endtask

  task automatic testNarrow();
    // cs2: 8-bit, all fields minimum
    cfgWrite(8'h18, mkCfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0));
    runAccess(1, 28'h4000104, 16'h5678, 0, 16'h0);  // re-establish last = cs1 write
    runAccess(0, 28'h8123457, 16'h0, 0, 16'h34C0);
    check(gWait == 3, "R11 cs change waits previous ta+1", gWait, 3);
    check(gCsPat == 4'b1011, "R3 cs2 decoded", gCsPat, 4'b1011);
    check(gAddr == 26'h0123457, "R8 8-bit address", gAddr, 26'h0123457);
    check(gRd == 16'h00C1, "R8 8-bit read upper zero", gRd, 16'h00C1);
    runAccess(0, 28'h8000001, 16'h0, 5, 16'h0010);
    check(gStrobe == 1, "R10 wait ignored when disabled", gStrobe, 1);
    runAccess(1, 28'h8000002, 16'hA55A, 0, 16'h0);
    check(gWait == 1, "R11 ta=0 reversal one idle", gWait, 1);
    check(gDout == 16'h005A && gDoe == 3, "R8 8-bit write data", {gDout, 8'(gDoe)}, {16'h005A, 8'd3});
  endtask

  task automatic testSelStrobe();
    cfgWrite(8'h1C, mkCfg(1, 0, 0, 0, 0, 1, 2, 1, 0, 1));
    runAccess(0, 28'hC000010, 16'h0, 0, 16'h0700);
    check(gStrobe == 3, "R9 strobe length", gStrobe, 3);
    check(gCsLow == 3 && gCsPat == 4'b0111, "R9 cs only in strobe", {8'(gCsLow), gCsPat}, {8'd3, 4'b0111});
    check(gPost == 2, "R9 hold still runs", gPost, 2);
  endtask

  task automatic testExtWait();
    cfgWrite(8'h10, mkCfg(0, 1, 0, 0, 0, 0, 1, 0, 0, 1));
    runAccess(0, 28'h0000100, 16'h0, 5, 16'h2000);
    check(gStrobe == 6, "R10 strobe stretched by wait", gStrobe, 6);
    check(gRd == 16'h2006, "R10 data captured after wait", gRd, 16'h2006);
    check(gCsPat == 4'b1110, "R3 cs0 decoded", gCsPat, 4'b1110);
    runAccess(0, 28'h0000100, 16'h0, 0, 16'h2000);
    check(gStrobe == 2, "R10 no wait keeps programmed strobe", gStrobe, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    @(negedge clk);
    testRead16();
    testWriteTurn();
    testNarrow();
    repeat (4) @(negedge clk);
    testSelStrobe();
    repeat (4) @(negedge clk);
    testExtWait();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule